// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This controller decides when each supply rail of a display power chip is switched on and off. It starts from an input-undervoltage flag and walks a fixed, dependency-ordered chain. First the internal linear rail comes up. Then a request is raised to the configuration-memory loader, and the core logic rail follows. Next come the I/O rail, a power-good indication and the negative gate rail. After a fixed wait, and only while the external enable pin is high, the load switch closes and the main analog and half-analog rails start together. The positive gate-high rail comes after them, and last the gate-pulse driver is armed.

Each regulator's soft start is outside the block. Each one reports back through a per-rail done flag, and the memory loader answers with a done flag. All delays are counted in pulses of a slow time-base tick, 0.5 ms per pulse by default. Simulation can therefore shorten time simply by pulsing the tick faster. The pins are all level control and status signals with no data transfer, so the block has no valid/ready handshake and no back-pressure.

A configuration mask can switch off any rail. The sequence then treats that rail as already up. A low enable pin takes down only the high-voltage group. Undervoltage takes everything down and restarts the chain from the beginning. A fault-latch input turns everything off until the next reset.

Top module: `pwrseq_top`

## Requirements
- R1: While `uvlo_i` is high (and out of reset), every output (`rail_en_o`, `ee_req_o`, `pgood_o`, `lsw_en_o`, `gpulse_en_o`) is low from the next clock on; nothing starts before it is released.
- R2: After lockout release the linear rail (`rail_en_o[0]`) is enabled alone; `ee_req_o` is raised only after that rail reports done and stays high until `ee_done_i`.
- R3: The core rail (`rail_en_o[1]`) is enabled only after `ee_done_i`, and the I/O rail (`rail_en_o[2]`) only after the core rail reports done.
- R4: In the cycle after the I/O rail reports done, `pgood_o` and the negative gate rail (`rail_en_o[3]`) rise together.
- R5: Exactly 5 tick pulses (2.5 ms at 0.5 ms per tick) after power-good rises, and only if `en_i` is high, `lsw_en_o`, the analog rail (`rail_en_o[4]`) and the half-analog rail (`rail_en_o[5]`) rise together. If `en_i` is low when the wait ends, they rise in the cycle after `en_i` goes high.
- R6: The gate-high rail (`rail_en_o[6]`) rises once the analog soft-start window has expired and the analog, half-analog and negative gate rails report done. The window is 20 ticks with `ss_sel_i`=0 and 40 ticks with `ss_sel_i`=1, counted from the rise of the analog rail.
- R7: `gpulse_en_o` rises only on a level change of `gctl_i` that arrives after the gate-high rail reports done; changes seen earlier do not arm it.
- R8: When `en_i` is low, the next clock drops `lsw_en_o`, `gpulse_en_o` and rail bits 4, 5 and 6, while bits 0 to 3 and `pgood_o` stay on. Raising `en_i` again restarts the analog rail in the following cycle, without the 5-tick wait.
- R9: Asserting `uvlo_i` turns all outputs off on the next clock; on release the chain starts again from the linear rail.
- R10: A set bit in `cfg_dis_i[i]` keeps `rail_en_o[i]` low, and the sequence continues as if that rail had reported done. Bit order is: 0 linear, 1 core, 2 I/O, 3 negative gate, 4 analog, 5 half-analog, 6 gate-high. A disabled analog rail also skips its soft-start window.
- R11: `fault_i` turns all outputs off on the next clock and keeps them off, whatever `uvlo_i` and `en_i` do, until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base pulse |
| uvlo_i | input | 1 | Input undervoltage lockout active |
| en_i | input | 1 | External enable for the high-voltage group |
| gctl_i | input | 1 | Gate-control input; any level change arms gate pulsing |
| ss_sel_i | input | 1 | Analog soft-start length select (0 short, 1 long) |
| fault_i | input | 1 | Global fault latch request |
| cfg_dis_i | input | 7 | Per-rail disable mask |
| ss_done_i | input | 7 | Per-rail soft-start done flags |
| ee_done_i | input | 1 | Configuration-memory auto-read complete |
| rail_en_o | output | 7 | Per-rail enables |
| ee_req_o | output | 1 | Auto-read request |
| pgood_o | output | 1 | Logic rails good |
| lsw_en_o | output | 1 | Load switch enable |
| gpulse_en_o | output | 1 | Gate-pulse driver enable |

## Verification
The bench measures the fixed wait and both soft-start windows in delivered tick pulses. A design that counted clock cycles, or that let the tick on the entry edge count, is off by one or more and gets caught. Gate-control edges are applied before the driver can arm and then checked to have no effect, which catches a detector that latches early edges. Enable is dropped in the high-voltage phase and held low across the end of the wait. This exposes designs that drop the logic rails, ignore the pin, or repeat the wait after re-enable. Random disable masks and plant latencies check that masked rails never switch on and that the chain still completes. A fault pulse followed by lockout toggles checks that only a reset clears the latch.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int NRAIL     = 7;
  localparam int RAIL_LIN  = 0;
  localparam int RAIL_CORE = 1;
  localparam int RAIL_IO   = 2;
  localparam int RAIL_NEG  = 3;
  localparam int RAIL_AN   = 4;
  localparam int RAIL_HALF = 5;
  localparam int RAIL_GH   = 6;

  typedef enum logic [3:0] {
    S_OFF   = 4'd0,
    S_LIN   = 4'd1,
    S_EE    = 4'd2,
    S_CORE  = 4'd3,
    S_IO    = 4'd4,
    S_DLY   = 4'd5,
    S_HOLD  = 4'd6,
    S_AN    = 4'd7,
    S_GH    = 4'd8,
    S_ARM   = 4'd9,
    S_RUN   = 4'd10,
    S_LATCH = 4'd11
  } seq_state_e;

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (tick_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !restart_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwrseq_edge.sv
module pwrseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign edge_o = sig_i ^ sig_q;

  // R7
  edge_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (sig_q != $past(sig_q)));

endmodule

// File: rtl/pwrseq_outmap.sv
module pwrseq_outmap
  import pwrseq_pkg::*;
(
  input  seq_state_e       state_i,
  input  logic [NRAIL-1:0] dis_i,
  output logic [NRAIL-1:0] rail_en_o,
  output logic             ee_req_o,
  output logic             pgood_o,
  output logic             lsw_en_o,
  output logic             gpulse_en_o
);

  logic [NRAIL-1:0] base;
  logic             logic_up;
  logic             hv_up;

  always_comb begin
    base     = '0;
    logic_up = 1'b0;
    hv_up    = 1'b0;
    unique case (state_i)
      S_LIN:  base[RAIL_LIN] = 1'b1;
      S_EE:   base[RAIL_LIN] = 1'b1;
      S_CORE: base[RAIL_CORE:RAIL_LIN] = '1;
      S_IO:   base[RAIL_IO:RAIL_LIN] = '1;
      S_DLY, S_HOLD: begin
        base[RAIL_NEG:RAIL_LIN] = '1;
        logic_up = 1'b1;
      end
      S_AN: begin
        base[RAIL_HALF:RAIL_LIN] = '1;
        logic_up = 1'b1;
        hv_up    = 1'b1;
      end
      S_GH, S_ARM, S_RUN: begin
        base     = '1;
        logic_up = 1'b1;
        hv_up    = 1'b1;
      end
      default: base = '0;
    endcase
  end

  for (genvar g = 0; g < NRAIL; g++) begin : g_mask
    assign rail_en_o[g] = base[g] & ~dis_i[g];
  end

  assign ee_req_o    = (state_i == S_EE);
  assign pgood_o     = logic_up;
  assign lsw_en_o    = hv_up;
  assign gpulse_en_o = (state_i == S_RUN);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int TICK_US     = 500,
  parameter int LSW_DLY_US  = 2500,
  parameter int SS_SHORT_US = 10000,
  parameter int SS_LONG_US  = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             uvlo_i,
  input  logic             en_i,
  input  logic             gctl_i,
  input  logic             ss_sel_i,
  input  logic             fault_i,
  input  logic [NRAIL-1:0] cfg_dis_i,
  input  logic [NRAIL-1:0] ss_done_i,
  input  logic             ee_done_i,
  output logic [NRAIL-1:0] rail_en_o,
  output logic             ee_req_o,
  output logic             pgood_o,
  output logic             lsw_en_o,
  output logic             gpulse_en_o
);

  localparam int LSW_TICKS      = LSW_DLY_US / TICK_US;
  localparam int SS_SHORT_TICKS = SS_SHORT_US / TICK_US;
  localparam int SS_LONG_TICKS  = SS_LONG_US / TICK_US;
  localparam int MAX_TICKS      = (SS_LONG_TICKS > LSW_TICKS) ? SS_LONG_TICKS : LSW_TICKS;
  localparam int CNT_W          = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] LIM_LSW   = CNT_W'(LSW_TICKS);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SS_SHORT_TICKS);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(SS_LONG_TICKS);

  seq_state_e       state_q, state_d;
  logic [NRAIL-1:0] done_eff;
  logic             tmr_restart, tmr_exp, gctl_edge, an_ready;
  logic [CNT_W-1:0] tmr_limit;

  assign done_eff    = ss_done_i | cfg_dis_i;
  assign tmr_restart = (state_d != state_q);
  assign tmr_limit   = (state_q == S_AN) ? (ss_sel_i ? LIM_LONG : LIM_SHORT) : LIM_LSW;
  assign an_ready    = (tmr_exp || cfg_dis_i[RAIL_AN]) && done_eff[RAIL_AN] &&
                       done_eff[RAIL_HALF] && done_eff[RAIL_NEG];

  pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tmr_restart),
    .tick_i    (tick_i),
    .limit_i   (tmr_limit),
    .expired_o (tmr_exp)
  );

  pwrseq_edge u_gedge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (gctl_i),
    .edge_o (gctl_edge)
  );

  always_comb begin
    state_d = state_q;
    if (fault_i || state_q == S_LATCH) begin
      state_d = S_LATCH;
    end else if (uvlo_i) begin
      state_d = S_OFF;
    end else begin
      unique case (state_q)
        S_OFF:  state_d = S_LIN;
        S_LIN:  if (done_eff[RAIL_LIN])  state_d = S_EE;
        S_EE:   if (ee_done_i)           state_d = S_CORE;
        S_CORE: if (done_eff[RAIL_CORE]) state_d = S_IO;
        S_IO:   if (done_eff[RAIL_IO])   state_d = S_DLY;
        S_DLY:  if (tmr_exp)             state_d = en_i ? S_AN : S_HOLD;
        S_HOLD: if (en_i)                state_d = S_AN;
        S_AN: begin
          if (!en_i)         state_d = S_HOLD;
          else if (an_ready) state_d = S_GH;
        end
        S_GH: begin
          if (!en_i)                     state_d = S_HOLD;
          else if (done_eff[RAIL_GH])    state_d = S_ARM;
        end
        S_ARM: begin
          if (!en_i)          state_d = S_HOLD;
          else if (gctl_edge) state_d = S_RUN;
        end
        S_RUN:   if (!en_i) state_d = S_HOLD;
        default: state_d = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_OFF;
    else        state_q <= state_d;
  end

  pwrseq_outmap u_outmap (
    .state_i     (state_q),
    .dis_i       (cfg_dis_i),
    .rail_en_o   (rail_en_o),
    .ee_req_o    (ee_req_o),
    .pgood_o     (pgood_o),
    .lsw_en_o    (lsw_en_o),
    .gpulse_en_o (gpulse_en_o)
  );

  // R1
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (rail_en_o == '0 && !ee_req_o && !pgood_o && !lsw_en_o && !gpulse_en_o));

  // R2
  ee_after_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req_o |-> (rail_en_o[RAIL_LIN] || cfg_dis_i[RAIL_LIN]));

  // R3
  io_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en_o[RAIL_IO] |-> (rail_en_o[RAIL_CORE] || cfg_dis_i[RAIL_CORE]));

  // R4
  pgood_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> (rail_en_o[RAIL_IO] || cfg_dis_i[RAIL_IO]));

  // R7
  gpulse_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpulse_en_o |-> lsw_en_o);

  // R8
  en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!lsw_en_o && !gpulse_en_o));

  // R11
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (rail_en_o == '0 && !pgood_o && !lsw_en_o && !ee_req_o));

  // R11
  latch_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LATCH) |=> (state_q == S_LATCH));

endmodule

// File: tb/pwrseq_top_tb.sv
`timescale 1ns/1ps
module pwrseq_top_tb;
  import pwrseq_pkg::*;

  localparam int TG    = 4;
  localparam int LSW_T = 5;
  localparam int SSS   = 20;
  localparam int SSL   = 40;

  logic clk = 0, rst_n = 0, tick = 0, uvlo = 1, en = 0, gctl = 0, ss_sel = 0, fault = 0;
  logic ee_done;
  logic [NRAIL-1:0] dis = '0, ss_done, rail_en;
  logic ee_req, pgood, lsw, gpulse;

  int checks = 0, errors = 0, tick_seen = 0;
  int pd[NRAIL];
  int pcnt[NRAIL];
  int ee_cnt = 0, ee_lat = 3;
  bit ee_seen = 0, order_bad = 0, mask_bad = 0;

  always #2.5 clk = ~clk;

  pwrseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .uvlo_i(uvlo), .en_i(en), .gctl_i(gctl),
    .ss_sel_i(ss_sel), .fault_i(fault), .cfg_dis_i(dis), .ss_done_i(ss_done),
    .ee_done_i(ee_done), .rail_en_o(rail_en), .ee_req_o(ee_req), .pgood_o(pgood),
    .lsw_en_o(lsw), .gpulse_en_o(gpulse)
  );

  // regulator and loader models
  always @(posedge clk) begin
    for (int i = 0; i < NRAIL; i++) pcnt[i] <= rail_en[i] ? pcnt[i] + 1 : 0;
    ee_cnt <= ee_req ? ee_cnt + 1 : 0;
    if (tick) tick_seen <= tick_seen + 1;
  end
  always_comb for (int i = 0; i < NRAIL; i++) ss_done[i] = rail_en[i] && (pcnt[i] >= pd[i]);
  assign ee_done = ee_req && (ee_cnt >= ee_lat);

  initial forever begin
    repeat (TG - 1) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  end

  always @(negedge clk) begin
    if (!rst_n || uvlo) ee_seen = 0;
    if (ee_req && ee_done) ee_seen = 1;
    if (rail_en[RAIL_CORE] && !ee_seen) order_bad = 1;
    if ((rail_en & dis) != '0) mask_bad = 1;
  end

  function automatic logic [NRAIL-1:0] exp_rails(int st, logic [NRAIL-1:0] m);
    logic [NRAIL-1:0] v;
    v = '0;
    if (st >= 1) v[RAIL_LIN] = 1;
    if (st >= 3) v[RAIL_CORE] = 1;
    if (st >= 4) v[RAIL_IO] = 1;
    if (st >= 5) v[RAIL_NEG] = 1;
    if (st >= 6) begin v[RAIL_AN] = 1; v[RAIL_HALF] = 1; end
    if (st >= 7) v[RAIL_GH] = 1;
    return v & ~m;
  endfunction

  function automatic int exp_ss(logic sel, logic an_dis);
    if (an_dis) return 0;
    return sel ? SSL : SSS;
  endfunction

  function automatic logic probe(int s);
    case (s)
      7: return ee_req;
      8: return pgood;
      9: return lsw;
      10: return gpulse;
      default: return rail_en[s];
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wait_hi(int s, string req);
    int n = 0;
    while (!probe(s) && n < 4000) begin @(negedge clk); n++; end
    if (!probe(s)) chk(0, req, "timeout waiting for output", s, 1);
  endtask

  function automatic logic all_off();
    return rail_en == '0 && !ee_req && !pgood && !lsw && !gpulse;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NRAIL; i++) pd[i] = 3;
    repeat (3) @(negedge clk);
    chk(all_off(), "R1", "outputs in reset", rail_en, 0);
    rst_n = 1;
    en = 1;
    repeat (20) @(negedge clk);
    chk(all_off(), "R1", "outputs while lockout held", rail_en, 0);

    // directed full bring-up
    uvlo = 0;
    wait_hi(0, "R2");
    chk(!ee_req && rail_en == exp_rails(1, dis), "R2", "linear rail alone", rail_en, exp_rails(1, dis));
    wait_hi(7, "R2");
    chk(rail_en == exp_rails(2, dis), "R2", "auto-read after linear done", rail_en, exp_rails(2, dis));
    wait_hi(1, "R3");
    chk(!ee_req && rail_en == exp_rails(3, dis), "R3", "core after auto-read", rail_en, exp_rails(3, dis));
    wait_hi(2, "R3");
    chk(!pgood && rail_en == exp_rails(4, dis), "R3", "io after core done", rail_en, exp_rails(4, dis));
    wait_hi(8, "R4");
    t0 = tick_seen;
    chk(rail_en == exp_rails(5, dis) && !lsw, "R4", "pgood with negative gate", rail_en, exp_rails(5, dis));
    wait_hi(9, "R5");
    chk(tick_seen - t0 == LSW_T, "R5", "ticks pgood to load switch", tick_seen - t0, LSW_T);
    chk(rail_en == exp_rails(6, dis), "R5", "analog group rails", rail_en, exp_rails(6, dis));
    t0 = tick_seen;
    @(negedge clk);
    gctl = 1;  // early edge, must not arm
    wait_hi(6, "R6");
    chk(tick_seen - t0 == exp_ss(0, 0), "R6", "short soft-start ticks", tick_seen - t0, exp_ss(0, 0));
    repeat (10) @(negedge clk);
    chk(!gpulse, "R7", "no arm from early edge", gpulse, 0);
    gctl = 0;
    @(negedge clk);
    chk(gpulse, "R7", "armed by edge", gpulse, 1);

    // enable low then high with long soft start
    en = 0;
    @(negedge clk);
    chk(!lsw && !gpulse && pgood && rail_en == exp_rails(5, dis), "R8", "enable low keeps logic", rail_en, exp_rails(5, dis));
    ss_sel = 1;
    repeat (7) @(negedge clk);
    en = 1;
    @(negedge clk);
    t0 = tick_seen;
    chk(lsw && rail_en == exp_rails(6, dis), "R8", "restart without wait", rail_en, exp_rails(6, dis));
    wait_hi(6, "R6");
    chk(tick_seen - t0 == exp_ss(1, 0), "R6", "long soft-start ticks", tick_seen - t0, exp_ss(1, 0));

    // lockout
    uvlo = 1;
    @(negedge clk);
    chk(all_off(), "R9", "lockout drops all", rail_en, 0);
    uvlo = 0;
    @(negedge clk);
    @(negedge clk);
    chk(rail_en == exp_rails(1, dis) && !ee_req, "R9", "chain restarts at linear", rail_en, exp_rails(1, dis));
    uvlo = 1;
    repeat (3) @(negedge clk);

    // masked rails and enable held low across the wait
    dis = 7'b0001100;
    en = 0;
    mask_bad = 0;
    uvlo = 0;
    wait_hi(8, "R10");
    chk(rail_en == exp_rails(5, dis), "R10", "io and negative gate masked", rail_en, exp_rails(5, dis));
    repeat ((LSW_T + 4) * TG) @(negedge clk);
    chk(!lsw, "R5", "enable low blocks load switch", lsw, 0);
    en = 1;
    @(negedge clk);
    chk(lsw, "R5", "load switch follows enable", lsw, 1);
    chk(!mask_bad, "R10", "masked rail never on", mask_bad, 0);
    uvlo = 1;
    repeat (3) @(negedge clk);

    // fault latch
    dis = '0;
    uvlo = 0;
    wait_hi(2, "R11");
    fault = 1;
    @(negedge clk);
    chk(all_off(), "R11", "fault drops all", rail_en, 0);
    fault = 0;
    uvlo = 1;
    repeat (5) @(negedge clk);
    uvlo = 0;
    repeat (50) @(negedge clk);
    chk(all_off(), "R11", "latched off after lockout toggle", rail_en, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(rail_en == exp_rails(1, dis), "R11", "reset clears latch", rail_en, exp_rails(1, dis));
    uvlo = 1;
    repeat (3) @(negedge clk);

    // random runs
    for (int it = 0; it < 8; it++) begin
      int ssw;
      dis = NRAIL'($urandom);
      for (int i = 0; i < NRAIL; i++) pd[i] = 1 + ($urandom % 6);
      ee_lat = 1 + ($urandom % 8);
      ss_sel = $urandom % 2;
      en = 1;
      mask_bad = 0;
      order_bad = 0;
      repeat (3) @(negedge clk);
      uvlo = 0;
      wait_hi(8, "R4");
      t0 = tick_seen;
      chk(rail_en == exp_rails(5, dis), "R4", "random logic rails", rail_en, exp_rails(5, dis));
      wait_hi(9, "R5");
      chk(tick_seen - t0 == LSW_T, "R5", "random wait ticks", tick_seen - t0, LSW_T);
      chk(rail_en == exp_rails(6, dis), "R10", "random analog rails", rail_en, exp_rails(6, dis));
      ssw = exp_ss(ss_sel, dis[RAIL_AN]);
      repeat ((ssw + 4) * TG + 20) @(negedge clk);
      chk(rail_en == exp_rails(7, dis) && !gpulse, "R6", "random full rails", rail_en, exp_rails(7, dis));
      gctl = ~gctl;
      @(negedge clk);
      chk(gpulse, "R7", "random arm", gpulse, 1);
      chk(!mask_bad, "R10", "random mask respected", mask_bad, 0);
      chk(!order_bad, "R3", "core only after auto-read", order_bad, 0);
      uvlo = 1;
      @(negedge clk);
      chk(all_off(), "R9", "random lockout", rail_en, 0);
    end

    summary();
    $finish;
  end

endmodule